// File: doc/BRIEF.md
# Fractional Clock Divider Synthesizer

This block derives a slower clock from its input clock. The ratio is set by a fixed-point division factor with 3 integer bits and 14 fractional bits, and the output runs at the input frequency divided by twice that factor. Each half-period of the output lasts the factor's value in input cycles, on average. A phase accumulator carries the fractional remainder from one half-period to the next. The long-run period is therefore exact, and any single half-period is the floor or the ceiling of the factor.

Software programs the block through a small 32-bit register port. The 17-bit factor sits in the low bits. The upper 15 bits are a spare control field that a factor write never disturbs. A new factor is first held in a shadow copy and is applied only at the next output edge, so a change never cuts a half-period short. A factor of zero stops the output low and raises a zero-rate flag. A nonzero factor below 1.0 is treated as 1.0.

Top module: `frac_clk_synth`

## Requirements
- R1: After synchronous reset, `clk_out` is 0, `zero_rate` is 0, `reg_rdata` reads 32'h0000_4000, and the output toggles on every input cycle (factor 1.0).
- R2: With effective factor E (raw value in units of 2^-14), the time taken by 2K consecutive output toggles is 2K*E/2^14 input cycles, within one cycle.
- R3: The output changes only when the accumulator crosses the factor, and each half-period lasts floor(E/2^14) or ceil(E/2^14) input cycles.
- R4: A write with `reg_sel`=0 loads `reg_wdata[16:0]` as the raw factor, which reads back on `reg_rdata[16:0]` on the next cycle, and leaves `reg_rdata[31:17]` unchanged.
- R5: A write with `reg_sel`=1 loads `reg_wdata[31:17]` into the spare field, which reads back on `reg_rdata[31:17]`, and leaves the factor bits unchanged.
- R6: A new factor takes effect only at the next output toggle, so the half-period in progress completes at the old length.
- R7: A raw factor from 1 to 0x3FFF behaves as 0x4000 (output = input/2), while the register still reads back the raw value written.
- R8: A raw factor of 0 holds `clk_out` at 0 and drives `zero_rate` to 1. From that state, a nonzero factor is applied on the next cycle and the output restarts.
- R9: `out_rise` is 1 for exactly the cycles in which `clk_out` has just changed from 0 to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0: write the factor field, 1: write the spare field |
| reg_wdata | input | 32 | Write data, full word |
| reg_rdata | output | 32 | Read data: spare field in bits 31:17, raw factor in bits 16:0 |
| clk_out | output | 1 | Synthesized output clock |
| out_rise | output | 1 | One-cycle pulse when clk_out goes high |
| zero_rate | output | 1 | High while the applied factor is zero |

## Verification
On every cycle, the assertions check the following:
- the output changes only after an accumulator crossing;
- the accumulator remainder stays below the applied factor;
- the applied factor changes only at a toggle, or while the output is stopped;
- a stopped output is low;
- the rise pulse matches the output edge;
- each register field reads back what was written, and the other field holds.

Only the bench scenarios can show the long-run properties: the average period over many toggles for several factors, the alternating half-period lengths, and the clamping of small factors. They also cover the exact length of the half-period that straddles a factor change.

// File: rtl/fs_pkg.sv
package fs_pkg;
  localparam int FACTOR_W = 17;
  localparam int FRAC_W   = 14;
  localparam int REG_W    = 32;
  localparam int SPARE_W  = REG_W - FACTOR_W;
  localparam int ACC_W    = FACTOR_W + 1;

  typedef logic [FACTOR_W-1:0] factor_t;
  typedef logic [ACC_W-1:0]    acc_t;
  typedef logic [SPARE_W-1:0]  spare_t;

  localparam factor_t UNIT = factor_t'(1) << FRAC_W;

  // Raw value to the factor actually used: zero stays zero, sub-unit clamps up
  function automatic factor_t fs_effective(input factor_t raw);
    if (raw == '0)       return '0;
    else if (raw < UNIT) return UNIT;
    else                 return raw;
  endfunction

  // One input cycle of phase advance
  function automatic acc_t fs_step(input acc_t acc);
    return acc + acc_t'(UNIT);
  endfunction

  // Crossing test: a nonzero factor reached by the advanced phase
  function automatic logic fs_cross(input acc_t nxt, input factor_t eff);
    return (eff != '0) && (nxt >= acc_t'(eff));
  endfunction
endpackage

// File: rtl/fs_regport.sv
module fs_regport
  import fs_pkg::*;
#(
  parameter factor_t RESET_FACTOR = UNIT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic             sel,
  input  logic [REG_W-1:0] wdata,
  input  logic             take,
  output factor_t          shadow_q,
  output logic             pending_q,
  output logic [REG_W-1:0] rdata
);
  spare_t spare_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      spare_q   <= '0;
      shadow_q  <= RESET_FACTOR;
      pending_q <= 1'b0;
    end else begin
      if (take) pending_q <= 1'b0;
      if (wr && !sel) begin
        shadow_q  <= wdata[FACTOR_W-1:0];
        pending_q <= 1'b1;
      end
      if (wr && sel) spare_q <= wdata[REG_W-1:FACTOR_W];
    end
  end

  assign rdata = {spare_q, shadow_q};
endmodule

// File: rtl/fs_phase_acc.sv
module fs_phase_acc
  import fs_pkg::*;
#(
  parameter factor_t RESET_FACTOR = UNIT
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    load,
  input  factor_t load_raw,
  output logic    tick,
  output acc_t    acc_q,
  output factor_t active_eff,
  output logic    active_zero
);
  factor_t active_raw_q;
  acc_t    acc_nxt;

  assign active_eff  = fs_effective(active_raw_q);
  assign active_zero = (active_eff == '0);
  assign acc_nxt     = fs_step(acc_q);
  assign tick        = fs_cross(acc_nxt, active_eff);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q        <= '0;
      active_raw_q <= RESET_FACTOR;
    end else begin
      if (active_zero)   acc_q <= '0;
      else if (tick)     acc_q <= acc_nxt - acc_t'(active_eff);
      else               acc_q <= acc_nxt;
      if (load) active_raw_q <= load_raw;
    end
  end
endmodule

// File: rtl/fs_toggle_out.sv
module fs_toggle_out (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic active_zero,
  input  logic load_zero,
  output logic clk_out,
  output logic out_rise
);
  logic out_nxt;

  always_comb begin
    if (active_zero || load_zero) out_nxt = 1'b0;
    else if (tick)                out_nxt = ~clk_out;
    else                          out_nxt = clk_out;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_out  <= 1'b0;
      out_rise <= 1'b0;
    end else begin
      clk_out  <= out_nxt;
      out_rise <= out_nxt & ~clk_out;
    end
  end
endmodule

// File: rtl/frac_clk_synth.sv
module frac_clk_synth
  import fs_pkg::*;
#(
  parameter factor_t RESET_FACTOR = UNIT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             clk_out,
  output logic             out_rise,
  output logic             zero_rate
);
  factor_t shadow_q;
  logic    pending_q;
  logic    tick;
  logic    load;
  logic    load_zero;
  acc_t    acc_q;
  factor_t active_eff;
  logic    active_zero;

  // Apply a pending factor at a toggle, or at once when stopped
  assign load      = pending_q && (tick || active_zero);
  assign load_zero = load && (fs_effective(shadow_q) == '0);
  assign zero_rate = active_zero;

  fs_regport #(.RESET_FACTOR(RESET_FACTOR)) u_regport (
    .clk(clk), .rst(rst), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
    .take(load), .shadow_q(shadow_q), .pending_q(pending_q), .rdata(reg_rdata)
  );

  fs_phase_acc #(.RESET_FACTOR(RESET_FACTOR)) u_phase (
    .clk(clk), .rst(rst), .load(load), .load_raw(shadow_q), .tick(tick),
    .acc_q(acc_q), .active_eff(active_eff), .active_zero(active_zero)
  );

  fs_toggle_out u_out (
    .clk(clk), .rst(rst), .tick(tick), .active_zero(active_zero),
    .load_zero(load_zero), .clk_out(clk_out), .out_rise(out_rise)
  );
endmodule

// File: rtl/fs_checker.sv
module fs_checker
  import fs_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             reg_wr,
  input logic             reg_sel,
  input logic [REG_W-1:0] reg_wdata,
  input logic [REG_W-1:0] reg_rdata,
  input logic             clk_out,
  input logic             out_rise,
  input logic             zero_rate,
  input logic             tick,
  input acc_t             acc_q,
  input factor_t          active_eff
);
  p_zero_low_r8: assert property (@(posedge clk) disable iff (rst)
    zero_rate |-> !clk_out);

  p_toggle_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
    (clk_out != $past(clk_out)) |-> $past(tick));

  p_acc_bound_r2: assert property (@(posedge clk) disable iff (rst)
    !zero_rate |-> (acc_q < acc_t'(active_eff)));

  p_factor_wr_r4: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !reg_sel) |=> (reg_rdata[FACTOR_W-1:0] == $past(reg_wdata[FACTOR_W-1:0]))
                             && $stable(reg_rdata[REG_W-1:FACTOR_W]));

  p_spare_wr_r5: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_sel) |=> (reg_rdata[REG_W-1:FACTOR_W] == $past(reg_wdata[REG_W-1:FACTOR_W]))
                            && $stable(reg_rdata[FACTOR_W-1:0]));

  p_factor_at_edge_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(active_eff) |-> ($past(tick) || $past(zero_rate)));

  p_rise_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    out_rise == (clk_out && !$past(clk_out)));
endmodule

bind frac_clk_synth fs_checker u_fs_checker (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .clk_out(clk_out),
  .out_rise(out_rise), .zero_rate(zero_rate), .tick(tick),
  .acc_q(acc_q), .active_eff(active_eff)
);

// File: tb/frac_clk_synth_bench.sv
`timescale 1ns/1ps
module frac_clk_synth_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        clk_out, out_rise, zero_rate;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  frac_clk_synth u_frac_clk_synth (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .clk_out(clk_out),
    .out_rise(out_rise), .zero_rate(zero_rate)
  );

  // Output monitor, sampled away from the active edge
  int  cyc = 0, rise_cnt = 0, last_rise = 0;
  int  tog_cnt = 0, last_tog = 0, tog_gap = 0;
  logic prev_out = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (clk_out && !prev_out) begin rise_cnt++; last_rise = cyc; end
    if (clk_out != prev_out) begin tog_cnt++; tog_gap = cyc - last_tog; last_tog = cyc; end
    prev_out = clk_out;
  end

  // {raw factor, expected effective factor}
  localparam logic [33:0] VECS [6] = '{
    {17'h04000, 17'h04000},
    {17'h0A000, 17'h0A000},
    {17'h06000, 17'h06000},
    {17'h1FFFF, 17'h1FFFF},
    {17'h02000, 17'h04000},
    {17'h0C555, 17'h0C555}
  };

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_reg(input bit sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wait_tog(output int gap);
    int s;
    @(posedge clk);
    s = tog_cnt;
    while (tog_cnt == s) @(posedge clk);
    gap = tog_gap;
  endtask

  task automatic measure_rises(input int k, output int cycles);
    int s, start;
    @(posedge clk);
    s = rise_cnt;
    while (rise_cnt == s) @(posedge clk);
    start = last_rise;
    s = rise_cnt;
    while (rise_cnt < s + k) @(posedge clk);
    cycles = last_rise - start;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int g, cycles, snap;
    longint expc, diff;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 rdata", reg_rdata, 32'h0000_4000);
    check("R1 zero_rate", zero_rate, 0);
    wait_tog(g); wait_tog(g);
    check("R1 gap at 1.0", g, 1);

    // R2/R7 vector table: average period and readback
    for (int i = 0; i < 6; i++) begin
      logic [16:0] raw, eff;
      raw = VECS[i][33:17];
      eff = VECS[i][16:0];
      write_reg(1'b0, {15'h0, raw});
      check("R4/R7 readback", reg_rdata[16:0], raw);
      repeat (4) wait_tog(g);
      measure_rises(16, cycles);
      expc = (longint'(32) * eff + 8192) >> 14;
      diff = cycles - expc;
      if (diff < 0) diff = -diff;
      total++;
      if (diff > 1) begin
        bad++;
        $display("FAIL R2 vec %0d actual=%0d expected=%0d", i, cycles, expc);
      end
    end

    // R3 half-periods of 2.5 are 2 or 3
    write_reg(1'b0, 32'h0000_A000);
    repeat (4) wait_tog(g);
    for (int j = 0; j < 8; j++) begin
      wait_tog(g);
      total++;
      if (g != 2 && g != 3) begin
        bad++;
        $display("FAIL R3 actual=%0d expected=2or3", g);
      end
    end

    // R6 change mid half-period completes old length
    write_reg(1'b0, 32'h0001_0000);
    repeat (4) wait_tog(g);
    check("R6 settled gap", g, 4);
    wait_tog(g);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 32'h0000_4000;
    @(negedge clk);
    reg_wr = 1'b0;
    wait_tog(g);
    check("R6 old length kept", g, 4);
    wait_tog(g);
    check("R6 new length", g, 1);

    // R5 spare field, factor untouched
    write_reg(1'b1, 32'hABCD_0000 | 32'h0001_FFFF);
    check("R5 spare", reg_rdata[31:17], 15'h55E6);
    check("R5 factor kept", reg_rdata[16:0], 17'h04000);
    write_reg(1'b0, 32'h0000_6000);
    check("R4 spare kept", reg_rdata[31:17], 15'h55E6);

    // R8 zero factor stops output
    write_reg(1'b0, 32'h0000_0000);
    repeat (12) @(negedge clk);
    check("R8 zero_rate", zero_rate, 1);
    check("R8 out low", clk_out, 0);
    snap = tog_cnt;
    repeat (50) @(negedge clk);
    check("R8 no toggles", tog_cnt, snap);
    write_reg(1'b0, 32'h0000_4000);
    repeat (3) @(negedge clk);
    check("R8 restart flag", zero_rate, 0);
    snap = tog_cnt;
    repeat (6) @(negedge clk);
    check("R8 restart toggles", tog_cnt - snap, 6);

    // R9 rise pulse coincides with clk_out going high
    begin
      logic p;
      int errs;
      errs = 0;
      p = clk_out;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (out_rise != (clk_out && !p)) errs++;
        p = clk_out;
      end
      check("R9 rise pulse mismatches", errs, 0);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule